// File: doc/BRIEF.md
# Arbitrated Width-Converting Memory Port

This block sits between several requesting channels that share a 32-bit internal bus and one single-port memory that is 16 bits wide. Each channel presents a request together with a direction, a word address and (for writes) a 32-bit data word. A fixed-priority arbiter picks one channel. A sequencer then splits the 32-bit access into two 16-bit memory beats, maps the internal word address onto the memory's half-word address space, and returns a single completion pulse to the channel it served.

The memory is dynamic and needs periodic refresh. A free-running timer raises a refresh request every `REFRESH_PERIOD` cycles. The sequencer serves that request only between transactions. A transaction already in flight always finishes first, and a pending refresh is issued before any new grant.

The memory model the block expects is synchronous. A read beat issued in one cycle returns its data on `mem_rdata` in the following cycle. A write beat is taken on the clock edge that ends the beat cycle.

Top module: `mem_port_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle.
- R2: When several channels request in the same idle cycle, the channel with the lowest index is served first. The remaining channels are served afterwards in ascending index order.
- R3: A write to internal word address A produces two memory beats in consecutive cycles, both with `mem_we` high. The first beat goes to memory address 2*A and carries data bits 15:0. The second goes to 2*A+1 and carries bits 31:16.
- R4: A read to internal word address A issues two read beats, to 2*A and then 2*A+1. In the cycle after the second beat, `done` pulses for exactly one cycle, on the served channel only. In that cycle `rdata` holds the word at 2*A+1 in bits 31:16 and the word at 2*A in bits 15:0.
- R5: The grant for a transaction rises with its first beat and stays unchanged through its completion pulse. A request from a higher-priority channel that arrives meanwhile does not pre-empt it.
- R6: With no traffic, `mem_refresh` pulses for one cycle every `REFRESH_PERIOD` cycles.
- R7: `mem_refresh` is never high together with `mem_en` or any grant. A pending refresh is issued in the cycle after the idle cycle that sees it, ahead of any new grant. Under continuous traffic, refreshes still occur about once per period.
- R8: While reset is held and in the first cycle after it, `grant`, `done`, `mem_en` and `mem_refresh` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_req | input | NCH | Per-channel request, held until `done` |
| ch_we | input | NCH | Per-channel direction, 1 = write |
| ch_addr | input | NCH*IADDR_W | Per-channel internal word address, channel i in slice i |
| ch_wdata | input | NCH*32 | Per-channel write data, channel i in slice i |
| grant | output | NCH | One-hot grant of the channel being served |
| done | output | NCH | One-cycle completion pulse to the served channel |
| rdata | output | 32 | Assembled read word, valid with `done` |
| mem_en | output | 1 | Memory beat strobe |
| mem_we | output | 1 | Memory write enable for the beat |
| mem_addr | output | IADDR_W+1 | Memory half-word address |
| mem_wdata | output | 16 | Memory write data for the beat |
| mem_rdata | input | 16 | Memory read data, one cycle after the read beat |
| mem_refresh | output | 1 | One-cycle refresh command |

## Verification
A sequencer stuck in a state or skipping one shows within a few cycles. The completion pulse goes missing or arrives early, or the bench sees more or fewer than two beats for a transaction. A wrong latched address or a swapped half-select corrupts the memory image. Every address is written and then read back, so that corruption appears as a read-back mismatch within one sweep. Priority and pre-emption faults change the order in which simultaneous requesters complete. A timer that miscounts changes the spacing between refresh pulses seen on an idle bus.

// File: rtl/mpa_pkg.sv
// Package: shared constants and sequencer state type for the memory port.
// Assumes a fixed 2:1 ratio between internal bus width and memory width.
package mpa_pkg;
    localparam int BUS_W = 32;
    localparam int MEM_W = 16;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_REFRESH,
        SQ_BEAT_LO,
        SQ_BEAT_HI,
        SQ_FINISH
    } seq_state_t;
endpackage

// File: rtl/mpa_arbiter.sv
// Fixed-priority picker: lowest-indexed active request wins.
// Purely combinational; clk/rst_n feed only the local assertions.
module mpa_arbiter #(
    parameter int NCH   = 3,
    parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req,
    output logic [IDX_W-1:0] pick_idx,
    output logic             pick_valid
);
    // Scan from the top so the lowest set index is the last assignment.
    always_comb begin
        pick_idx   = '0;
        pick_valid = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_idx   = IDX_W'(i);
                pick_valid = 1'b1;
            end
        end
    end

    a_r2_pick_is_requester: assert property (@(posedge clk) disable iff (!rst_n)
        pick_valid |-> req[pick_idx]);
    a_r2_valid_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_valid |-> (req == '0));
endmodule

// File: rtl/mpa_refresh_timer.sv
// Refresh timer: free-running counter that sets a sticky pending flag once
// per PERIOD cycles; the flag clears when the sequencer acknowledges it.
// Assumes PERIOD is well above the longest transaction (4 cycles).
module mpa_refresh_timer #(
    parameter int PERIOD = 32,
    localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    logic [CNT_W-1:0] cnt;
    logic             tick;

    assign tick = (cnt == CNT_W'(PERIOD - 1));

    // Count cycles and wrap at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // Hold the request until served; a new tick takes precedence over ack.
    always_ff @(posedge clk) begin
        if (!rst_n)    pending <= 1'b0;
        else if (tick) pending <= 1'b1;
        else if (ack)  pending <= 1'b0;
    end

    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && ack && !tick) |=> !pending);
    a_r6_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> pending);
endmodule

// File: rtl/mpa_addr_map.sv
// Address decoder: maps an internal 32-bit word address plus a half select
// onto the 16-bit memory's address space (word A -> half-words 2A, 2A+1).
module mpa_addr_map #(
    parameter int IADDR_W = 4,
    localparam int MADDR_W = IADDR_W + 1
) (
    input  logic [IADDR_W-1:0] word_addr,
    input  logic               upper_half,
    output logic [MADDR_W-1:0] mem_addr
);
    // Half select becomes the least significant address bit.
    always_comb mem_addr = {word_addr, upper_half};
endmodule

// File: rtl/mpa_sequencer.sv
// Transaction sequencer: latches the picked channel's request in an idle
// cycle, issues the low and high 16-bit beats, assembles read data and
// pulses completion. Refresh is taken only from idle and ahead of grants.
// Assumes memory read data arrives one cycle after the read beat.
module mpa_sequencer
    import mpa_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int IADDR_W = 4,
    parameter int IDX_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         ch_we,
    input  logic [NCH*IADDR_W-1:0] ch_addr,
    input  logic [NCH*BUS_W-1:0]   ch_wdata,
    input  logic [IDX_W-1:0]       pick_idx,
    input  logic                   pick_valid,
    input  logic                   ref_pending,
    input  logic [MEM_W-1:0]       mem_rdata,
    output logic [NCH-1:0]         grant,
    output logic [NCH-1:0]         done,
    output logic [BUS_W-1:0]       rdata,
    output logic                   beat_en,
    output logic                   beat_we,
    output logic                   beat_upper,
    output logic [IADDR_W-1:0]     cur_addr,
    output logic [MEM_W-1:0]       beat_wdata,
    output logic                   ref_ack
);
    seq_state_t         state;
    logic [IDX_W-1:0]   gidx;
    logic               cur_we;
    logic [BUS_W-1:0]   cur_wdata;
    logic [MEM_W-1:0]   lo_q;
    logic               busy;
    logic [NCH-1:0]     gidx_onehot;

    // Advance the sequencer; latch the winner's request when leaving idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            gidx      <= '0;
            cur_we    <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (ref_pending) begin
                        state <= SQ_REFRESH;
                    end else if (pick_valid) begin
                        gidx      <= pick_idx;
                        cur_we    <= ch_we[pick_idx];
                        cur_addr  <= ch_addr[pick_idx*IADDR_W +: IADDR_W];
                        cur_wdata <= ch_wdata[pick_idx*BUS_W +: BUS_W];
                        state     <= SQ_BEAT_LO;
                    end
                end
                SQ_REFRESH: state <= SQ_IDLE;
                SQ_BEAT_LO: state <= SQ_BEAT_HI;
                SQ_BEAT_HI: state <= SQ_FINISH;
                SQ_FINISH:  state <= SQ_IDLE;
                default:    state <= SQ_IDLE;
            endcase
        end
    end

    // Capture the low read half returned for the first beat.
    always_ff @(posedge clk) begin
        if (!rst_n)                   lo_q <= '0;
        else if (state == SQ_BEAT_HI) lo_q <= mem_rdata;
    end

    // Decode beat controls, grant, completion and refresh from the state.
    always_comb begin
        busy        = (state == SQ_BEAT_LO) || (state == SQ_BEAT_HI) || (state == SQ_FINISH);
        gidx_onehot = NCH'(1) << gidx;
        grant       = busy ? gidx_onehot : '0;
        done        = (state == SQ_FINISH) ? gidx_onehot : '0;
        rdata       = (state == SQ_FINISH) ? {mem_rdata, lo_q} : '0;
        beat_en     = (state == SQ_BEAT_LO) || (state == SQ_BEAT_HI);
        beat_we     = beat_en && cur_we;
        beat_upper  = (state == SQ_BEAT_HI);
        beat_wdata  = !beat_en ? '0 :
                      beat_upper ? cur_wdata[BUS_W-1:MEM_W] : cur_wdata[MEM_W-1:0];
        ref_ack     = (state == SQ_REFRESH);
    end

    a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r5_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && !(|done)) |=> $stable(grant));
    a_r7_refresh_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && ref_pending) |=> (ref_ack && grant == '0));
endmodule

// File: rtl/mem_port_arbiter.sv
// Top level: arbitrated, width-converting port from NCH 32-bit channels to
// one 16-bit single-port dynamic memory with periodic refresh insertion.
// Channels hold request and fields stable until their done pulse.
module mem_port_arbiter
    import mpa_pkg::*;
#(
    parameter int NCH            = 3,
    parameter int IADDR_W        = 4,
    parameter int REFRESH_PERIOD = 32,
    localparam int MADDR_W = IADDR_W + 1,
    localparam int IDX_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         ch_req,
    input  logic [NCH-1:0]         ch_we,
    input  logic [NCH*IADDR_W-1:0] ch_addr,
    input  logic [NCH*32-1:0]      ch_wdata,
    output logic [NCH-1:0]         grant,
    output logic [NCH-1:0]         done,
    output logic [31:0]            rdata,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [MADDR_W-1:0]     mem_addr,
    output logic [15:0]            mem_wdata,
    input  logic [15:0]            mem_rdata,
    output logic                   mem_refresh
);
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_valid;
    logic               ref_pending;
    logic               ref_ack;
    logic               beat_upper;
    logic [IADDR_W-1:0] cur_addr;

    mpa_arbiter #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (ch_req),
        .pick_idx   (pick_idx),
        .pick_valid (pick_valid)
    );

    mpa_refresh_timer #(.PERIOD(REFRESH_PERIOD)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pending)
    );

    mpa_sequencer #(.NCH(NCH), .IADDR_W(IADDR_W), .IDX_W(IDX_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_we       (ch_we),
        .ch_addr     (ch_addr),
        .ch_wdata    (ch_wdata),
        .pick_idx    (pick_idx),
        .pick_valid  (pick_valid),
        .ref_pending (ref_pending),
        .mem_rdata   (mem_rdata),
        .grant       (grant),
        .done        (done),
        .rdata       (rdata),
        .beat_en     (mem_en),
        .beat_we     (mem_we),
        .beat_upper  (beat_upper),
        .cur_addr    (cur_addr),
        .beat_wdata  (mem_wdata),
        .ref_ack     (ref_ack)
    );

    mpa_addr_map #(.IADDR_W(IADDR_W)) u_map (
        .word_addr  (cur_addr),
        .upper_half (beat_upper),
        .mem_addr   (mem_addr)
    );

    assign mem_refresh = ref_ack;

    a_r3_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_addr[0]) |=> (mem_en && mem_addr[0] && $stable(mem_we)
            && mem_addr[MADDR_W-1:1] == $past(mem_addr[MADDR_W-1:1])));
    a_r4_done_to_grantee: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> ($onehot(done) && ((done & ~grant) == '0)));
    a_r4_done_after_high_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> $past(mem_en && mem_addr[0]));
    a_r7_refresh_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_refresh |-> (!mem_en && grant == '0));
endmodule

// File: tb/mem_port_arbiter_bench.sv
`timescale 1ns/1ps
module mem_port_arbiter_bench;
    localparam int NCH = 3;
    localparam int IW  = 4;
    localparam int MW  = IW + 1;
    localparam int PER = 32;
    localparam int NWORDS = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0]    ch_req = '0;
    logic [NCH-1:0]    ch_we = '0;
    logic [NCH*IW-1:0] ch_addr = '0;
    logic [NCH*32-1:0] ch_wdata = '0;
    logic [NCH-1:0]    grant, done;
    logic [31:0]       rdata;
    logic              mem_en, mem_we, mem_refresh;
    logic [MW-1:0]     mem_addr;
    logic [15:0]       mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    mem_port_arbiter #(.NCH(NCH), .IADDR_W(IW), .REFRESH_PERIOD(PER)) u_mem_port_arbiter (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_we(ch_we), .ch_addr(ch_addr),
        .ch_wdata(ch_wdata), .grant(grant), .done(done), .rdata(rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_refresh(mem_refresh)
    );

    // Simple synchronous 16-bit memory, read data one cycle after the beat.
    logic [15:0] mem [0:(1<<MW)-1];
    logic [15:0] mrd = '0;
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            else        mrd <= mem[mem_addr];
        end
    end
    assign mem_rdata = mrd;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [31:0] exp_mem [0:NWORDS-1];

    // Beat and refresh monitor, sampled away from the active edge.
    int          bn = 0;
    logic [MW-1:0] b_addr [0:1];
    logic [15:0] b_data [0:1];
    logic        b_we [0:1];
    int ref_count = 0, last_ref = 0, last_int = 0, ref_viol = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            if (bn < 2) begin
                b_addr[bn] = mem_addr; b_data[bn] = mem_wdata; b_we[bn] = mem_we;
            end
            bn = bn + 1;
        end
        if (rst_n && mem_refresh) begin
            last_int = cyc - last_ref;
            last_ref = cyc;
            ref_count = ref_count + 1;
            if (grant != '0 || mem_en) ref_viol = ref_viol + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One transaction on channel ch; checks grant, beats and completion.
    task automatic run_one(input int ch, input bit w, input int a, input logic [31:0] d);
        int t;
        bit seen;
        bit grant_ok;
        @(negedge clk);
        ch_we[ch] = w;
        ch_addr[ch*IW +: IW] = IW'(a);
        ch_wdata[ch*32 +: 32] = d;
        ch_req[ch] = 1'b1;
        bn = 0;
        seen = 0;
        grant_ok = 1;
        for (t = 0; t < 60 && !seen; t++) begin
            @(negedge clk);
            if (grant != '0 && grant != (NCH'(1) << ch)) grant_ok = 0;
            if (done[ch]) begin
                seen = 1;
                ch_req[ch] = 1'b0;
                chk(grant == (NCH'(1) << ch), "R5 grant at done", 64'(grant), 64'(NCH'(1) << ch));
                if (!w) chk(rdata == exp_mem[a], "R4 read data", 64'(rdata), 64'(exp_mem[a]));
            end
        end
        chk(seen, "R4 done seen", 64'(seen), 64'd1);
        chk(grant_ok, "R1 only own grant", 64'(grant_ok), 64'd1);
        chk(bn == 2, "R3/R4 two beats", 64'(bn), 64'd2);
        chk(b_addr[0] == MW'(2*a) && b_addr[1] == MW'(2*a+1), "R3 beat addresses",
            64'({b_addr[0], b_addr[1]}), 64'({MW'(2*a), MW'(2*a+1)}));
        chk(b_we[0] == w && b_we[1] == w, "R3 beat direction", 64'({b_we[0], b_we[1]}), 64'({w, w}));
        if (w) chk({b_data[1], b_data[0]} == d, "R3 low half first", 64'({b_data[1], b_data[0]}), 64'(d));
        @(negedge clk);
        chk(done == '0, "R4 single pulse", 64'(done), 64'd0);
    endtask

    initial begin
        // R8: reset state.
        repeat (3) @(negedge clk);
        chk(grant == '0 && done == '0 && !mem_en && !mem_refresh, "R8 during reset",
            64'({grant, done, mem_en, mem_refresh}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grant == '0 && done == '0 && !mem_en && !mem_refresh, "R8 after reset",
            64'({grant, done, mem_en, mem_refresh}), 64'd0);

        // R3: write every address, rotating channels.
        for (int a = 0; a < NWORDS; a++) begin
            exp_mem[a] = (32'(a) * 32'h0103_0507) ^ 32'hA5C3_5A3C;
            run_one(a % NCH, 1'b1, a, exp_mem[a]);
        end
        // R4: read every address back from a different channel.
        for (int a = 0; a < NWORDS; a++) run_one((a + 1) % NCH, 1'b0, a, 32'd0);

        // R2: every combination of simultaneous requesters, served lowest first.
        for (int p = 1; p < (1 << NCH); p++) begin
            int remaining;
            int t;
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                if (p[c]) begin
                    ch_we[c] = 1'b0;
                    ch_addr[c*IW +: IW] = IW'(c * 5 + p);
                    ch_req[c] = 1'b1;
                end
            end
            remaining = p;
            for (t = 0; t < 200 && remaining != 0; t++) begin
                @(negedge clk);
                for (int c = 0; c < NCH; c++) begin
                    if (done[c]) begin
                        int lowest;
                        lowest = 0;
                        while (!remaining[lowest]) lowest++;
                        chk(c == lowest, "R2 service order", 64'(c), 64'(lowest));
                        chk(rdata == exp_mem[(c * 5 + p) % NWORDS], "R4 concurrent read",
                            64'(rdata), 64'(exp_mem[(c * 5 + p) % NWORDS]));
                        remaining[c] = 1'b0;
                        ch_req[c] = 1'b0;
                    end
                end
            end
            chk(remaining == 0, "R2 all served", 64'(remaining), 64'd0);
        end

        // R5: a higher-priority request mid-transaction does not pre-empt.
        begin
            int t;
            int first;
            bit g_ok;
            @(negedge clk);
            ch_we[2] = 1'b0; ch_addr[2*IW +: IW] = IW'(9); ch_req[2] = 1'b1;
            first = -1;
            g_ok = 1;
            for (t = 0; t < 40 && grant == '0; t++) @(negedge clk);
            ch_we[0] = 1'b0; ch_addr[0 +: IW] = IW'(3); ch_req[0] = 1'b1;
            for (t = 0; t < 80 && ch_req != '0; t++) begin
                @(negedge clk);
                if (first < 0 && grant != '0 && grant != 3'b100) g_ok = 0;
                for (int c = 0; c < NCH; c++) if (done[c]) begin
                    if (first < 0) first = c;
                    ch_req[c] = 1'b0;
                end
            end
            chk(g_ok, "R5 grant held", 64'(g_ok), 64'd1);
            chk(first == 2, "R5 no pre-emption", 64'(first), 64'd2);
        end

        // R7: refreshes kept up during the busy phase, never overlapped.
        chk(ref_count >= (cyc / PER) - 1, "R7 refresh under traffic", 64'(ref_count), 64'(cyc / PER));
        chk(ref_viol == 0, "R7 refresh exclusive", 64'(ref_viol), 64'd0);

        // R6: idle spacing equals the period.
        begin
            int r0;
            int t;
            r0 = ref_count;
            for (t = 0; t < 5 * PER && ref_count < r0 + 3; t++) @(negedge clk);
            chk(ref_count >= r0 + 3, "R6 refresh present", 64'(ref_count - r0), 64'd3);
            chk(last_int == PER, "R6 refresh spacing", 64'(last_int), 64'(PER));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule